// File: doc/BRIEF.md
# E1 Sa Bit Source Selector with Biframe Aligner

This block picks the five Sa bits (Sa4 to Sa8) that the transmit framer inserts into each outgoing NOT FAS frame. There are five possible sources: a static value kept in a control register, a facility data link that is fed either by an external serial input or by an internal HDLC engine, a transmit Sa stack, and Sa data passed through from the system-side stream. Each source arrives here already packed as a 5-bit word for each frame. The block latches the chosen word when the framer strobes `tx_nfas_i`, and holds it on `sa_o` until the next strobe.

When the system side supplies the Sa bits, that stream must follow a biframe rhythm. Bit 2 of its time slot 0 is 1 in frames that carry Sa data, and 0 in the FAS frame that comes next. The block locks onto this alternation and reports loss of biframe alignment on `lobf_o`. When the alternation breaks, it searches again. It also pulses `realign_o` each time a new alignment is found. No search takes place until the mode field has held the system code at least once since reset.

Top module: `e1sa_source_sel`

## Requirements
- R1: While reset is held and in the cycle after it, `sa_o` = 5'b11111, `lobf_o` = 1 and `realign_o` = 0.
- R2: Mode 3'b000 together with `static_mask_i` = 5'b11111 loads `static_sa_i` into `sa_o` at a strobe. Mode 000 with any other mask loads 5'b11111.
- R3: Mode 3'b1xx loads `fdl_ext_i` when `fdl_ext_sel_i` = 1 and `hdlc_sa_i` when it is 0.
- R4: Mode 3'b010 and mode 3'b011 both load `stack_sa_i`.
- R5: In mode 3'b001 while aligned, a strobe loads the `sys_sa_i` of the latest system frame that had TS0 bit 2 = 1 at a position where a 1 was expected.
- R6: Until `mode_i` has equalled 3'b001 on at least one clock edge since reset, `lobf_o` stays 1 whatever the system frames carry.
- R7: Once armed, alignment is declared after two consecutive 1-then-0 pairs of TS0 bit 2. `lobf_o` falls, and `realign_o` is 1 for exactly one cycle, in the cycle after the frame that completes the second pair.
- R8: While aligned, the first system frame whose TS0 bit 2 equals the bit 2 of the previous frame sets `lobf_o` in the next cycle.
- R9: In mode 3'b001 while `lobf_o` = 1, a strobe loads 5'b11111.
- R10: `sa_o` changes only in the cycle after a `tx_nfas_i` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Sa source mode field |
| static_mask_i | input | 5 | Enable mask; the static source is used only when all bits are 1 |
| static_sa_i | input | 5 | Static Sa value |
| fdl_ext_sel_i | input | 1 | 1 = external data link input, 0 = internal HDLC |
| fdl_ext_i | input | 5 | Sa word from the external data link |
| hdlc_sa_i | input | 5 | Sa word from the internal HDLC |
| stack_sa_i | input | 5 | Sa word from the transmit stack |
| sys_frame_i | input | 1 | One-cycle strobe marking a system-side frame |
| sys_b2_i | input | 1 | TS0 bit 2 of that system frame |
| sys_sa_i | input | 5 | Sa bits carried by that system frame |
| tx_nfas_i | input | 1 | Strobe requesting the Sa word for the next transmit NOT FAS frame |
| sa_o | output | 5 | Registered Sa word to insert |
| lobf_o | output | 1 | Loss of biframe alignment |
| realign_o | output | 1 | One-cycle pulse when a new alignment is found |

## Verification
The bench aims at the lock threshold. A design that locked after a single pair would clear `lobf_o` one pair early, and one that counted pairs across a broken run would lock on a pattern that was never clean. It sends bit-2 patterns before the mode has been armed, because a design that searched without arming would align too early. It also sends a repeated bit while aligned, which a design with delayed or filtered loss detection would let pass, and it checks that such a design would not force all-ones onto the system source. Random mode and data sweeps cover the partial static mask and both data link select settings, where a decoder with a wrong priority would emit the wrong word.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  localparam int SA_W = 5;

  typedef enum logic [2:0] {
    SRC_IDLE, SRC_STATIC, SRC_EXT, SRC_HDLC, SRC_STACK, SRC_SYS
  } src_e;

  localparam logic [2:0] MODE_SYS = 3'b001;

  function automatic src_e decode_src(input logic [2:0] mode,
                                      input logic mask_full,
                                      input logic ext_sel);
    src_e s;
    if (mode[2])                s = ext_sel ? SRC_EXT : SRC_HDLC;
    else if (mode[1])           s = SRC_STACK;
    else if (mode[0])           s = SRC_SYS;
    else if (mask_full)         s = SRC_STATIC;
    else                        s = SRC_IDLE;
    return s;
  endfunction
endpackage

// File: rtl/e1sa_biframe_align.sv
module e1sa_biframe_align #(
  parameter int SA_W       = 5,
  parameter int LOCK_PAIRS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm_i,
  input  logic            frm_i,
  input  logic            b2_i,
  input  logic [SA_W-1:0] sa_i,
  output logic            lobf_o,
  output logic            realign_o,
  output logic [SA_W-1:0] hold_o
);
  localparam int CW = $clog2(LOCK_PAIRS + 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_PAIRS - 1);

  logic          armed_q;
  logic          exp_q;
  logic [CW-1:0] pairs_q;
  logic          match;

  assign match = (b2_i == exp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      exp_q     <= 1'b1;
      pairs_q   <= '0;
      lobf_o    <= 1'b1;
      realign_o <= 1'b0;
      hold_o    <= '1;
    end else begin
      realign_o <= 1'b0;
      if (arm_i) armed_q <= 1'b1;
      if (frm_i && armed_q) begin
        exp_q <= ~b2_i;
        if (match) begin
          if (b2_i) hold_o <= sa_i;
          if (!b2_i && lobf_o) begin
            if (pairs_q == LOCK_LAST) begin
              lobf_o    <= 1'b0;
              realign_o <= 1'b1;
              pairs_q   <= '0;
            end else begin
              pairs_q <= pairs_q + 1'b1;
            end
          end
        end else begin
          lobf_o  <= 1'b1;
          pairs_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/e1sa_src_mux.sv
module e1sa_src_mux
  import e1sa_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] static_mask_i,
  input  logic [W-1:0] static_sa_i,
  input  logic         fdl_ext_sel_i,
  input  logic [W-1:0] fdl_ext_i,
  input  logic [W-1:0] hdlc_sa_i,
  input  logic [W-1:0] stack_sa_i,
  input  logic [W-1:0] sys_hold_i,
  input  logic         lobf_i,
  output logic [W-1:0] sa_next_o
);
  src_e src;
  assign src = decode_src(mode_i, &static_mask_i, fdl_ext_sel_i);

  always_comb begin
    case (src)
      SRC_STATIC: sa_next_o = static_sa_i;
      SRC_EXT:    sa_next_o = fdl_ext_i;
      SRC_HDLC:   sa_next_o = hdlc_sa_i;
      SRC_STACK:  sa_next_o = stack_sa_i;
      SRC_SYS:    sa_next_o = lobf_i ? '1 : sys_hold_i;
      default:    sa_next_o = '1;
    endcase
  end
endmodule

// File: rtl/e1sa_source_sel.sv
module e1sa_source_sel
  import e1sa_pkg::*;
#(
  parameter int W          = SA_W,
  parameter int LOCK_PAIRS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] static_mask_i,
  input  logic [W-1:0] static_sa_i,
  input  logic         fdl_ext_sel_i,
  input  logic [W-1:0] fdl_ext_i,
  input  logic [W-1:0] hdlc_sa_i,
  input  logic [W-1:0] stack_sa_i,
  input  logic         sys_frame_i,
  input  logic         sys_b2_i,
  input  logic [W-1:0] sys_sa_i,
  input  logic         tx_nfas_i,
  output logic [W-1:0] sa_o,
  output logic         lobf_o,
  output logic         realign_o
);
  logic [W-1:0] sys_hold;
  logic [W-1:0] sa_next;

  e1sa_biframe_align #(.SA_W(W), .LOCK_PAIRS(LOCK_PAIRS)) u_align (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (mode_i == MODE_SYS),
    .frm_i     (sys_frame_i),
    .b2_i      (sys_b2_i),
    .sa_i      (sys_sa_i),
    .lobf_o    (lobf_o),
    .realign_o (realign_o),
    .hold_o    (sys_hold)
  );

  e1sa_src_mux #(.W(W)) u_mux (
    .mode_i        (mode_i),
    .static_mask_i (static_mask_i),
    .static_sa_i   (static_sa_i),
    .fdl_ext_sel_i (fdl_ext_sel_i),
    .fdl_ext_i     (fdl_ext_i),
    .hdlc_sa_i     (hdlc_sa_i),
    .stack_sa_i    (stack_sa_i),
    .sys_hold_i    (sys_hold),
    .lobf_i        (lobf_o),
    .sa_next_o     (sa_next)
  );

  always_ff @(posedge clk) begin
    if (rst)            sa_o <= '1;
    else if (tx_nfas_i) sa_o <= sa_next;
  end
endmodule

// File: rtl/e1sa_source_sel_chk.sv
module e1sa_source_sel_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   mode_i,
  input logic         sys_frame_i,
  input logic         sys_b2_i,
  input logic         tx_nfas_i,
  input logic [W-1:0] sa_o,
  input logic         lobf_o,
  input logic         realign_o
);
  logic seen_sys_q;
  logic last_b2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_sys_q <= 1'b0;
      last_b2_q  <= 1'b0;
    end else begin
      if (mode_i == 3'b001) seen_sys_q <= 1'b1;
      if (sys_frame_i)      last_b2_q  <= sys_b2_i;
    end
  end

  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> (sa_o == '1 && lobf_o && !realign_o)); // R1

  AST_NO_SEARCH_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !seen_sys_q |-> lobf_o); // R6

  AST_REALIGN_ON_LOCK: assert property (@(posedge clk) disable iff (rst)
    realign_o |-> $fell(lobf_o)); // R7

  AST_REALIGN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    realign_o |=> !realign_o); // R7

  AST_LOSS_FIRST_MISS: assert property (@(posedge clk) disable iff (rst)
    (!lobf_o && sys_frame_i && sys_b2_i == last_b2_q) |=> lobf_o); // R8

  AST_SYS_LOST_ONES: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b001 && tx_nfas_i && lobf_o) |=> (sa_o == '1)); // R9

  AST_SA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tx_nfas_i |=> $stable(sa_o)); // R10
endmodule

bind e1sa_source_sel e1sa_source_sel_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .sys_frame_i (sys_frame_i),
  .sys_b2_i    (sys_b2_i),
  .tx_nfas_i   (tx_nfas_i),
  .sa_o        (sa_o),
  .lobf_o      (lobf_o),
  .realign_o   (realign_o)
);

// File: tb/e1sa_source_sel_tb.sv
module e1sa_source_sel_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] mode = 0;
  logic [4:0] mask = 0, stat = 0, ext = 0, hdlc = 0, stack = 0, ssa = 0;
  logic       ext_sel = 0, sfrm = 0, sb2 = 0, tx = 0;
  logic [4:0] sa;
  logic       lobf, realign;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  bit       m_armed = 0, m_lobf = 1, m_exp = 1, m_real = 0;
  int       m_cnt = 0;
  bit [4:0] m_hold = 5'h1F, m_sa = 5'h1F;

  always #2.5 clk = ~clk;

  e1sa_source_sel u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .static_mask_i(mask),
    .static_sa_i(stat), .fdl_ext_sel_i(ext_sel), .fdl_ext_i(ext),
    .hdlc_sa_i(hdlc), .stack_sa_i(stack), .sys_frame_i(sfrm),
    .sys_b2_i(sb2), .sys_sa_i(ssa), .tx_nfas_i(tx),
    .sa_o(sa), .lobf_o(lobf), .realign_o(realign)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic bit [4:0] exp_sa();
    if (mode[2])       return ext_sel ? ext : hdlc;
    if (mode[1])       return stack;
    if (mode[0])       return m_lobf ? 5'h1F : m_hold;
    if (mask == 5'h1F) return stat;
    return 5'h1F;
  endfunction

  // one cycle: inputs set at negedge, model stepped at posedge
  task automatic step(input bit do_tx, input bit do_frm, input bit b2, input bit [4:0] v);
    tx = do_tx; sfrm = do_frm; sb2 = b2; ssa = v;
    @(posedge clk);
    m_real = 0;
    if (do_tx) m_sa = exp_sa();
    if (do_frm && m_armed) begin
      if (b2 == m_exp) begin
        if (b2) m_hold = v;
        else if (m_lobf) begin
          m_cnt++;
          if (m_cnt == 2) begin m_lobf = 0; m_real = 1; m_cnt = 0; end
        end
      end else begin
        m_lobf = 1; m_cnt = 0;
      end
      m_exp = ~b2;
    end
    if (mode == 3'b001) m_armed = 1;
    @(negedge clk);
    tx = 0; sfrm = 0;
  endtask

  task automatic frame_chk(input string req, input bit b2, input bit [4:0] v);
    step(0, 1, b2, v);
    chk(req, lobf, m_lobf);
    chk(req, realign, m_real);
  endtask

  task automatic tx_chk(input string req);
    step(1, 0, 0, 0);
    chk(req, sa, m_sa);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7633));
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk("R1", sa, 5'h1F); chk("R1", lobf, 1); chk("R1", realign, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", sa, 5'h1F); chk("R1", lobf, 1);

    // R6: clean pattern before arming leaves lobf high
    mode = 3'b000;
    for (int i = 0; i < 6; i++) frame_chk("R6", i % 2 == 0, 5'h0A);
    chk("R6", lobf, 1);

    // R2 static: full mask and partial mask
    mask = 5'h1F; stat = 5'h05; tx_chk("R2");
    chk("R2", sa, 5'h05);
    mask = 5'h1E; tx_chk("R2");
    chk("R2", sa, 5'h1F);

    // R3 both link selections
    mode = 3'b100; ext = 5'h11; hdlc = 5'h06; ext_sel = 1; tx_chk("R3");
    chk("R3", sa, 5'h11);
    mode = 3'b111; ext_sel = 0; tx_chk("R3");
    chk("R3", sa, 5'h06);

    // R4 both stack codes
    mode = 3'b010; stack = 5'h19; tx_chk("R4");
    mode = 3'b011; stack = 5'h0C; tx_chk("R4");
    chk("R4", sa, 5'h0C);

    // arm, R9 while lost
    mode = 3'b001; tx_chk("R9");
    chk("R9", sa, 5'h1F);

    // R7: one pair is not enough, second pair locks
    frame_chk("R7", 1, 5'h03);
    frame_chk("R7", 0, 5'h00);
    chk("R7", lobf, 1);
    frame_chk("R7", 1, 5'h16);
    frame_chk("R7", 0, 5'h00);
    chk("R7", lobf, 0); chk("R7", realign, 1);
    step(0, 0, 0, 0);
    chk("R7", realign, 0);

    // R5 aligned passthrough
    tx_chk("R5");
    chk("R5", sa, 5'h16);
    frame_chk("R5", 1, 5'h09);
    frame_chk("R5", 0, 5'h00);
    tx_chk("R5");
    chk("R5", sa, 5'h09);

    // R10: frames and mode changes without strobe keep sa_o
    mode = 3'b100; ext_sel = 1; ext = 5'h02;
    frame_chk("R10", 1, 5'h1B);
    step(0, 0, 0, 0);
    chk("R10", sa, 5'h09);
    mode = 3'b001;

    // R8: repeated bit while aligned (last b2 was 1)
    chk("R8", lobf, 0);
    frame_chk("R8", 1, 5'h04);
    chk("R8", lobf, 1);
    tx_chk("R9");
    chk("R9", sa, 5'h1F);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) begin
        mode = 3'($urandom());
        mask = ($urandom_range(0, 1) != 0) ? 5'h1F : 5'($urandom());
        stat = 5'($urandom()); ext = 5'($urandom()); hdlc = 5'($urandom());
        stack = 5'($urandom()); ext_sel = 1'($urandom());
        tx_chk("R2 R3 R4 R5 R9 random");
      end else begin
        bit b = ($urandom_range(0, 11) == 0) ? ~m_exp : m_exp;
        frame_chk("R7 R8 random", b, 5'($urandom()));
        chk("R10 random", sa, m_sa);
      end
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule